// File: doc/BRIEF.md
# Double-Buffered DMA Byte-Count Controller

This block keeps the remaining byte counts for one memory-to-memory DMA channel that works from two buffer descriptors. Software loads a 16-bit count into either of two count registers. Loading a nonzero count is the only step needed to arm that buffer, because the address registers elsewhere in the channel keep their values. While the channel is enabled, each completed write-to-memory address phase is signalled by a one-cycle strobe. The strobe takes one from the count of the active buffer. When that count reaches zero, the channel moves on to the other buffer if that buffer is armed. If it is not, the channel reports completion and waits.

A second function tracks an external request line through a status bit. In edge mode a rising edge on the synchronized line sets the bit, and a software write to the status register clears it, so the channel drops that request. In level mode the bit simply follows the synchronized line, and writes to the status register change nothing.

Top module: `dma_dbuf_count`

## Requirements
- R1: After reset both counts read 0, `busy`, `done` and `err` are 0, `active_buf` is 0 and `req_status` is 0.
- R2: A write to offset 0x10 loads buffer 0's count and a write to 0x14 loads buffer 1's count, both from write-data bits 15:0. A read of either offset returns the live count in bits 15:0 and zero in bits 31:16.
- R3: While running, each `xfer_done` strobe reduces the active buffer's nonzero count by exactly one on the next clock edge, and leaves the other buffer's count unchanged.
- R4: When the active count reaches zero and the other count is nonzero, `active_buf` switches to the other buffer one cycle later.
- R5: When both counts are zero while running, `done` rises and further strobes change nothing. A later nonzero count write resumes the channel (`busy`=1, `done`=0) one cycle after the write takes effect.
- R6: Raising `ch_enable` while both counts are zero sets `err`. No count changes while `err` is set, and `err` holds until `ch_enable` falls.
- R7: On start, the channel keeps the current `active_buf` if that buffer's count is nonzero and otherwise takes the other buffer.
- R8: When a count write and a strobe hit the active buffer in the same cycle, the written value is kept.
- R9: With `level_mode`=0, a rising edge of `ext_req` sets `req_status` on the third clock edge. A write to the status register at offset 0x0C clears it. A request that stays high does not set it again.
- R10: With `level_mode`=1, `req_status` equals `ext_req` delayed by two clock edges, and status writes do not change it.
- R11: Lowering `ch_enable` returns the channel to idle on the next edge and clears `busy`, `done` and `err`. Both counts keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on `bus_addr`) |
| ch_enable | input | 1 | Channel enable |
| level_mode | input | 1 | 1: level-sensitive request, 0: edge-sensitive |
| xfer_done | input | 1 | One-cycle strobe per completed write-to-memory address phase |
| ext_req | input | 1 | Asynchronous external request |
| active_buf | output | 1 | Index of the buffer being consumed |
| busy | output | 1 | Channel running on an armed buffer |
| done | output | 1 | Both buffers drained while enabled |
| err | output | 1 | Enabled with no armed buffer |
| req_status | output | 1 | Request status bit |

## Verification
A table of count pairs drives the main decrement path. The table covers counts split across both buffers, a run that starts on an empty buffer, a run in which only one buffer is loaded, a full-scale count, and extra strobes sent after both buffers are drained. Between them, these pairs separate a wrong decrement step, a missed or premature buffer switch, a wrong start choice and a missing completion stop. Directed tests then cover the start with both counts zero, resuming from completion by a count write alone, the write-against-strobe collision, and both request modes. The request tests include a held request after a clear and a status write in level mode.

// File: rtl/dbc_pkg.sv
// Shared types and register offsets for the double-buffered byte-count block.
// Assumes byte offsets within a channel window of at least 5 address bits.
package dbc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2,
        ST_ERR  = 2'd3
    } dbc_state_e;

    localparam logic [7:0] OFF_STAT     = 8'h0C;
    localparam logic [7:0] OFF_CNT_BASE = 8'h10;
    localparam logic [7:0] OFF_CNT_STEP = 8'h04;
    localparam int         NUM_BUF      = 2;
endpackage

// File: rtl/dbc_count_reg.sv
// One buffer's remaining byte count. A software write loads it, and a
// decrement request takes one from a nonzero value. If both arrive in the
// same cycle, the write wins. Assumes dec_en is a single-cycle strobe.
module dbc_count_reg #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             dec_en,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load on write, otherwise count down on a qualified strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (wr_en)
            cnt_q <= wr_val;
        else if (dec_en && cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign cnt_o = cnt_q;

    assert_dec_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && !wr_en && cnt_o != '0) |=> cnt_o == $past(cnt_o) - CNT_W'(1));

    assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cnt_o == $past(wr_val));
endmodule

// File: rtl/dbc_sync_edge.sv
// Multi-flop synchronizer for an asynchronous level, with a rising-edge
// pulse taken from the synchronized output. Assumes STAGES >= 2.
module dbc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q <= '0;
        else
            chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    // Keep last synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else
            prev_q <= chain_q[STAGES-1];
    end

    assign sync_o = chain_q[STAGES-1];
    assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/dbc_req_status.sv
// Request status bit. In edge mode a synchronized rising edge sets a sticky
// flag that a status write clears. In level mode the bit is the synchronized
// line itself and status writes are ignored. A new edge beats a clear.
module dbc_req_status #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_in,
    input  logic level_mode,
    input  logic clr_wr,
    output logic stat_o
);
    logic req_sync;
    logic req_rise;
    logic edge_q;

    dbc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (req_in),
        .sync_o   (req_sync),
        .rise_o   (req_rise)
    );

    // Sticky edge flag, held clear while in level mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            edge_q <= 1'b0;
        else if (level_mode)
            edge_q <= 1'b0;
        else if (req_rise)
            edge_q <= 1'b1;
        else if (clr_wr)
            edge_q <= 1'b0;
    end

    assign stat_o = level_mode ? req_sync : edge_q;

    assert_clear_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && clr_wr && !req_rise) |=> !edge_q);
endmodule

// File: rtl/dbc_seq.sv
// Channel sequencer. It picks the buffer to consume, moves to the other
// buffer when the active one is empty, and reports completion or a start
// without work. A buffer counts as armed while its count is nonzero.
// Strobes are ignored in the cycle in which a switch is taken.
module dbc_seq
    import dbc_pkg::*;
#(
    parameter int NBUF = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            xfer_stb,
    input  logic [NBUF-1:0] valid,
    output logic            act_o,
    output dbc_state_e      state_o,
    output logic [NBUF-1:0] dec_o
);
    dbc_state_e state_q;
    logic       act_q;
    logic       pick;

    // Start choice: stay on the current buffer if armed, else take the other.
    always_comb pick = valid[act_q] ? act_q : ~act_q;

    // Channel state and active-buffer pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            act_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (enable) begin
                    if (|valid) begin
                        state_q <= ST_RUN;
                        act_q   <= pick;
                    end else begin
                        state_q <= ST_ERR;
                    end
                end
                ST_RUN: if (!enable) begin
                    state_q <= ST_IDLE;
                end else if (!valid[act_q]) begin
                    if (valid[~act_q]) act_q   <= ~act_q;
                    else               state_q <= ST_DONE;
                end
                ST_DONE: if (!enable) begin
                    state_q <= ST_IDLE;
                end else if (|valid) begin
                    state_q <= ST_RUN;
                    act_q   <= pick;
                end
                default: if (!enable) state_q <= ST_IDLE;
            endcase
        end
    end

    // Route a completed-transfer strobe to the active armed buffer.
    always_comb begin
        dec_o = '0;
        if (state_q == ST_RUN && valid[act_q] && xfer_stb)
            dec_o[act_q] = 1'b1;
    end

    assign act_o   = act_q;
    assign state_o = state_q;

    assert_disable_idles_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> state_o == ST_IDLE);

    assert_switch_on_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_RUN && act_q != $past(act_q))
            |-> ($past(valid) & (act_q ? 2'b01 : 2'b10)) == 2'b00);
endmodule

// File: rtl/dma_dbuf_count.sv
// Top of the double-buffered byte-count block: register decode, two count
// registers, the sequencer and the request status bit. Reads are
// combinational, and unmapped offsets read zero.
module dma_dbuf_count
    import dbc_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ch_enable,
    input  logic              level_mode,
    input  logic              xfer_done,
    input  logic              ext_req,
    output logic              active_buf,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              req_status
);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(OFF_STAT);

    logic [CNT_W-1:0]   cnt [NUM_BUF];
    logic [NUM_BUF-1:0] cnt_wr;
    logic [NUM_BUF-1:0] valid;
    logic [NUM_BUF-1:0] dec;
    logic               stat_wr;
    logic               any_wr;
    dbc_state_e         state;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

    // One count register per buffer at its own offset.
    for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
        localparam logic [ADDR_W-1:0] MY_ADDR =
            ADDR_W'(OFF_CNT_BASE + OFF_CNT_STEP * i);

        assign cnt_wr[i] = bus_wr && (bus_addr == MY_ADDR);
        assign valid[i]  = |cnt[i];

        dbc_count_reg #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (cnt_wr[i]),
            .wr_val (bus_wdata[CNT_W-1:0]),
            .dec_en (dec[i]),
            .cnt_o  (cnt[i])
        );
    end

    assign stat_wr = bus_wr && (bus_addr == STAT_ADDR);
    assign any_wr  = |cnt_wr;

    dbc_seq #(.NBUF(NUM_BUF)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (ch_enable),
        .xfer_stb (xfer_done),
        .valid    (valid),
        .act_o    (active_buf),
        .state_o  (state),
        .dec_o    (dec)
    );

    dbc_req_status #(.SYNC_STAGES(SYNC_STAGES)) u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_in     (ext_req),
        .level_mode (level_mode),
        .clr_wr     (stat_wr),
        .stat_o     (req_status)
    );

    assign busy = (state == ST_RUN);
    assign done = (state == ST_DONE);
    assign err  = (state == ST_ERR);

    // Read mux: live counts, status bit, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == STAT_ADDR)
            bus_rdata[0] = req_status;
        for (int i = 0; i < NUM_BUF; i++) begin
            if (bus_addr == ADDR_W'(OFF_CNT_BASE + OFF_CNT_STEP * i))
                bus_rdata[CNT_W-1:0] = cnt[i];
        end
    end

    assert_done_both_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && !$past(any_wr)) |-> (cnt[0] == '0 && cnt[1] == '0));

    assert_err_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !any_wr) |=> (cnt[0] == $past(cnt[0]) && cnt[1] == $past(cnt[1])));
endmodule

// File: tb/dma_dbuf_count_tb.sv
module dma_dbuf_count_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_STAT = 8'h0C;
    localparam logic [7:0] A_C0   = 8'h10;
    localparam logic [7:0] A_C1   = 8'h14;
    localparam int NVEC = 8;
    // {count0, count1, strobes}
    localparam logic [35:0] VECS [NVEC] = '{
        {16'd3,     16'd2, 4'd2},
        {16'd3,     16'd2, 4'd5},
        {16'd0,     16'd4, 4'd3},
        {16'd1,     16'd0, 4'd1},
        {16'd5,     16'd5, 4'd7},
        {16'd2,     16'd0, 4'd4},
        {16'hFFFF,  16'd1, 4'd3},
        {16'd1,     16'd1, 4'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ch_enable = 1'b0;
    logic        level_mode = 1'b0;
    logic        xfer_done = 1'b0;
    logic        ext_req = 1'b0;
    logic        active_buf, busy, done, err, req_status;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_dbuf_count dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_enable(ch_enable),
        .level_mode(level_mode), .xfer_done(xfer_done), .ext_req(ext_req),
        .active_buf(active_buf), .busy(busy), .done(done), .err(err),
        .req_status(req_status)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse();
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [15:0] m [2];
        logic        mact;

        step(3);
        rst_n = 1'b1;
        // R1 reset state
        rd(A_C0, d); check("R1 cnt0", d, 0);
        rd(A_C1, d); check("R1 cnt1", d, 0);
        check("R1 busy", {31'b0, busy}, 0);
        check("R1 done", {31'b0, done}, 0);
        check("R1 err", {31'b0, err}, 0);
        check("R1 active", {31'b0, active_buf}, 0);
        check("R1 req_status", {31'b0, req_status}, 0);

        // R2 register access
        wr(A_C0, 32'hABCD1234);
        rd(A_C0, d); check("R2 cnt0 upper bits", d, 32'h00001234);
        rd(A_C1, d); check("R2 cnt1 untouched", d, 0);
        wr(A_C1, 32'h00000005);
        rd(A_C1, d); check("R2 cnt1 load", d, 5);

        // Vector table: R3 decrement, R4 switch, R5 done, R7 start choice
        mact = 1'b0;
        for (int v = 0; v < NVEC; v++) begin
            ch_enable = 1'b0;
            step(2);
            m[0] = VECS[v][35:20];
            m[1] = VECS[v][19:4];
            wr(A_C0, {16'h0, m[0]});
            wr(A_C1, {16'h0, m[1]});
            if (m[mact] == 16'd0) mact = ~mact;
            ch_enable = 1'b1;
            step(1);
            for (int k = 0; k < int'(VECS[v][3:0]); k++) begin
                pulse();
                if (m[mact] != 16'd0) begin
                    m[mact] = m[mact] - 16'd1;
                    if (m[mact] == 16'd0 && m[~mact] != 16'd0) mact = ~mact;
                end
            end
            step(1);
            rd(A_C0, d); check($sformatf("R3 vec%0d cnt0", v), d, {16'h0, m[0]});
            rd(A_C1, d); check($sformatf("R3 vec%0d cnt1", v), d, {16'h0, m[1]});
            check($sformatf("R4 vec%0d active", v), {31'b0, active_buf}, {31'b0, mact});
            check($sformatf("R5 vec%0d done", v), {31'b0, done},
                  {31'b0, (m[0] == 16'd0 && m[1] == 16'd0)});
            check($sformatf("R5 vec%0d busy", v), {31'b0, busy},
                  {31'b0, !(m[0] == 16'd0 && m[1] == 16'd0)});
        end

        // R6 start with no work
        ch_enable = 1'b0; step(2);
        wr(A_C0, 0); wr(A_C1, 0);
        ch_enable = 1'b1; step(1);
        check("R6 err set", {31'b0, err}, 1);
        check("R6 not busy", {31'b0, busy}, 0);
        pulse();
        rd(A_C0, d); check("R6 cnt0 frozen", d, 0);
        check("R6 err held", {31'b0, err}, 1);
        ch_enable = 1'b0; step(1);
        check("R11 err cleared", {31'b0, err}, 0);

        // R5 resume from done by a count write alone
        step(1);
        wr(A_C0, 1);
        ch_enable = 1'b1; step(1);
        pulse(); step(1);
        check("R5 done after drain", {31'b0, done}, 1);
        pulse();
        rd(A_C1, d); check("R5 strobe ignored when done", d, 0);
        wr(A_C1, 2);
        step(1);
        check("R5 resumed busy", {31'b0, busy}, 1);
        check("R5 resumed done low", {31'b0, done}, 0);
        check("R7 resume picks buffer 1", {31'b0, active_buf}, 1);
        pulse();
        rd(A_C1, d); check("R3 resumed decrement", d, 1);

        // R8 write against strobe on the active buffer
        bus_wr = 1'b1; bus_addr = A_C1; bus_wdata = 32'd7; xfer_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; xfer_done = 1'b0;
        rd(A_C1, d); check("R8 write wins", d, 7);

        // R11 disable keeps counts
        ch_enable = 1'b0; step(1);
        check("R11 busy low", {31'b0, busy}, 0);
        rd(A_C1, d); check("R11 count kept", d, 7);

        // R7 start switches away from empty current buffer
        wr(A_C1, 0); wr(A_C0, 3);
        ch_enable = 1'b1; step(1);
        check("R7 start on buffer 0", {31'b0, active_buf}, 0);
        ch_enable = 1'b0; step(1);

        // R9 edge mode
        level_mode = 1'b0; ext_req = 1'b1;
        step(2);
        check("R9 not yet set", {31'b0, req_status}, 0);
        step(1);
        check("R9 set on edge", {31'b0, req_status}, 1);
        rd(A_STAT, d); check("R9 status read", d, 1);
        wr(A_STAT, 0);
        check("R9 cleared by write", {31'b0, req_status}, 0);
        step(3);
        check("R9 held request ignored", {31'b0, req_status}, 0);
        ext_req = 1'b0; step(3);
        ext_req = 1'b1; step(3);
        check("R9 new edge sets", {31'b0, req_status}, 1);

        // R10 level mode
        level_mode = 1'b1; step(1);
        check("R10 follows high", {31'b0, req_status}, 1);
        wr(A_STAT, 0);
        check("R10 write ignored", {31'b0, req_status}, 1);
        ext_req = 1'b0; step(1);
        check("R10 two-edge delay", {31'b0, req_status}, 1);
        step(1);
        check("R10 follows low", {31'b0, req_status}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule